// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flag Register

A 16-bit arithmetic-logic unit for a simple integer execution stage. It performs addition, addition with incoming carry, subtraction, subtraction with incoming borrow, compare, and bitwise AND, OR and XOR. The result comes out combinationally. The unit also produces six status bits: carry/borrow, nibble auxiliary carry, even parity of the low byte, zero, sign and signed overflow. A size select switches the operation between the full 16-bit word and the low byte only.

The status bits are written into a 9-bit flags register on the clock edge at which the update enable is high. The same register holds three control bits: direction, interrupt enable and single-step trap. These bits change only through explicit set and clear command inputs, never through an arithmetic or logic operation. A compare computes a subtraction so that the flags can be updated. It drops the result write-enable, so the destination is not written.

Top module: `alu_flags_unit`

## Requirements
- R1: For ADD (op 0) and ADC (op 1), result_o is the sum a + b (+ carry_i for ADC) modulo the selected size. Flag bit 0 (carry) is the carry out of the top bit of the selected size.
- R2: For SUB (op 2), SBB (op 3) and CMP (op 4), the difference is a - b (- carry_i for SBB). Flag bit 0 is set when the subtraction needs a borrow, meaning the unsigned a is smaller than b plus the incoming borrow.
- R3: Flag bit 5 (overflow) is set when the true two's-complement result of an arithmetic operation lies outside the signed range of the selected size.
- R4: Flag bit 3 (zero) is set when the sized result is zero. Flag bit 4 (sign) equals result bit 15 in word mode and result bit 7 in byte mode.
- R5: Flag bit 1 (parity) is 1 when result bits 7:0 hold an even number of ones, and 0 otherwise.
- R6: Flag bit 2 (auxiliary) marks a carry out of bit 3 for addition, or a borrow into bit 4 for subtraction, including the incoming carry or borrow.
- R7: AND (op 5), OR (op 6) and XOR (op 7) give the bitwise result. They clear the carry, overflow and auxiliary flags.
- R8: With byte_i high, only bits 7:0 of the operands take part, sign and overflow are judged at bit 7, and result_o[15:8] is zero.
- R9: result_we_o is low for CMP and high for every other op. CMP produces the same flags as SUB.
- R10: Flags bits 5:0 load the new status on the rising edge where upd_i is high, and are visible on flags_o after that edge. With upd_i low they hold.
- R11: The control bits are direction (flags bit 6), interrupt (bit 7) and trap (bit 8). They map to index 0, 1 and 2 of ctl_set_i and ctl_clr_i. A set command forces its bit to 1 and a clear command forces it to 0, with clear winning when both are given. upd_i and the operation have no effect on these bits.
- R12: While rst_ni is low, flags_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| op_i | input | 3 | Operation code (0 ADD … 7 XOR) |
| byte_i | input | 1 | 1 selects byte size, 0 word size |
| carry_i | input | 1 | Incoming carry/borrow for ADC and SBB |
| upd_i | input | 1 | Load status bits into the flags register |
| ctl_set_i | input | 3 | Set commands for direction, interrupt, trap |
| ctl_clr_i | input | 3 | Clear commands for direction, interrupt, trap |
| result_o | output | 16 | Sized result |
| result_we_o | output | 1 | Result write-enable, low for compare |
| flags_o | output | 9 | Flags register |

## Verification
The datapath has no internal state, so a wrong sum, borrow or logic result appears on result_o in the same cycle as the inputs that caused it. A wrong status bit, or a status bit captured when upd_i was low, appears on flags_o right after the next rising edge and stays there until the next update. Control bits that a status load or a set/clear mix-up has corrupted can stay wrong for many cycles. The bench therefore compares the control field after every cycle against a model that changes it only on commands.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_ADC = 3'd1, OP_SUB = 3'd2, OP_SBB = 3'd3,
    OP_CMP = 3'd4, OP_AND = 3'd5, OP_OR  = 3'd6, OP_XOR = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
  localparam int CTL_W    = 3;
  localparam int FLAGS_W  = STATUS_W + CTL_W;
endpackage

// File: rtl/alu_flags_addsub.sv
module alu_flags_addsub #(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              cin_i,
  input  logic              byte_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cry_o,
  output logic              aux_o,
  output logic              ovf_o
);
  logic [DATA_W:0] ext;
  logic [DATA_W:0] cin_ext;
  logic sa, sb, sr;

  assign cin_ext = {{DATA_W{1'b0}}, cin_i};

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i} - cin_ext;
    else       ext = {1'b0, a_i} + {1'b0, b_i} + cin_ext;
  end

  assign res_o = ext[DATA_W-1:0];
  // operands are pre-masked in byte mode, so bit BYTE_W is the carry/borrow
  assign cry_o = byte_i ? ext[BYTE_W] : ext[DATA_W];
  assign aux_o = a_i[4] ^ b_i[4] ^ ext[4];

  assign sa = byte_i ? a_i[BYTE_W-1] : a_i[DATA_W-1];
  assign sb = byte_i ? b_i[BYTE_W-1] : b_i[DATA_W-1];
  assign sr = byte_i ? ext[BYTE_W-1] : ext[DATA_W-1];
  assign ovf_o = sub_i ? ((sa ^ sb) & (sr ^ sa)) : (~(sa ^ sb) & (sr ^ sa));
endmodule

// File: rtl/alu_flags_logic.sv
module alu_flags_logic
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags_reg.sv
module alu_flags_reg
  import alu_flags_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               upd_i,
  input  status_t            status_i,
  input  logic [CTL_W-1:0]   set_i,
  input  logic [CTL_W-1:0]   clr_i,
  output logic [FLAGS_W-1:0] flags_o
);
  status_t            status_q;
  logic [CTL_W-1:0]   ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    status_q <= '0;
    else if (upd_i) status_q <= status_i;
  end

  for (genvar i = 0; i < CTL_W; i++) begin : g_ctl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ctl_q[i] <= 1'b0;
      else if (clr_i[i]) ctl_q[i] <= 1'b0;
      else if (set_i[i]) ctl_q[i] <= 1'b1;
    end
  end

  assign flags_o = {ctl_q, status_q};
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  op_a_i,
  input  logic [DATA_W-1:0]  op_b_i,
  input  logic [2:0]         op_i,
  input  logic               byte_i,
  input  logic               carry_i,
  input  logic               upd_i,
  input  logic [CTL_W-1:0]   ctl_set_i,
  input  logic [CTL_W-1:0]   ctl_clr_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_we_o,
  output logic [FLAGS_W-1:0] flags_o
);
  localparam logic [DATA_W-1:0] BYTE_MASK = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

  alu_op_e           op;
  logic [DATA_W-1:0] mask, am, bm, arith_res, logic_res, res;
  logic              is_logic, is_sub, cin;
  logic              a_cry, a_aux, a_ovf;
  status_t           status;

  assign op       = alu_op_e'(op_i);
  assign mask     = byte_i ? BYTE_MASK : '1;
  assign am       = op_a_i & mask;
  assign bm       = op_b_i & mask;
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign cin      = ((op == OP_ADC) || (op == OP_SBB)) & carry_i;

  alu_flags_addsub #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_addsub (
    .a_i(am), .b_i(bm), .sub_i(is_sub), .cin_i(cin), .byte_i(byte_i),
    .res_o(arith_res), .cry_o(a_cry), .aux_o(a_aux), .ovf_o(a_ovf)
  );

  alu_flags_logic #(.DATA_W(DATA_W)) i_logic (
    .a_i(am), .b_i(bm), .op_i(op), .res_o(logic_res)
  );

  assign res = (is_logic ? logic_res : arith_res) & mask;

  always_comb begin
    status.cry = ~is_logic & a_cry;
    status.aux = ~is_logic & a_aux;
    status.ovf = ~is_logic & a_ovf;
    status.zro = (res == '0);
    status.sgn = byte_i ? res[BYTE_W-1] : res[DATA_W-1];
    status.par = ~^res[7:0];
  end

  alu_flags_reg i_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_i(upd_i), .status_i(status),
    .set_i(ctl_set_i), .clr_i(ctl_clr_i), .flags_o(flags_o)
  );

  assign result_o    = res;
  assign result_we_o = (op != OP_CMP);
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  op_i,
  input logic        byte_i,
  input logic        upd_i,
  input logic [2:0]  ctl_set_i,
  input logic [2:0]  ctl_clr_i,
  input logic [15:0] result_o,
  input logic        result_we_o,
  input logic [8:0]  flags_o
);
  assert_cmp_no_we_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4) == !result_we_o);

  assert_byte_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |-> (result_o[15:8] == 8'h00));

  assert_logic_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && op_i >= 3'd5) |=> (flags_o[0] == 1'b0 && flags_o[2] == 1'b0 && flags_o[5] == 1'b0));

  assert_zero_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (flags_o[3] == ($past(result_o) == 16'h0000)));

  assert_parity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (flags_o[1] == ~^$past(result_o[7:0])));

  assert_status_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(flags_o[5:0]));

  assert_ctl_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_set_i == 3'b000 && ctl_clr_i == 3'b000) |=> $stable(flags_o[8:6]));

  always_comb begin
    if (!rst_ni) assert_reset_zero_R12: assert (flags_o == 9'h000);
  end
endmodule

bind alu_flags_unit alu_flags_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .byte_i(byte_i), .upd_i(upd_i),
  .ctl_set_i(ctl_set_i), .ctl_clr_i(ctl_clr_i), .result_o(result_o),
  .result_we_o(result_we_o), .flags_o(flags_o)
);

// File: tb/test_alu_flags_unit.sv
`timescale 1ns/1ps
module test_alu_flags_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [2:0]  op = '0;
  logic        byt = 1'b0, cin = 1'b0, upd = 1'b0;
  logic [2:0]  cset = '0, cclr = '0;
  logic [15:0] result;
  logic        we;
  logic [8:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [5:0] exp_st = '0;
  logic [2:0] exp_ctl = '0;

  always #10 clk = ~clk;

  alu_flags_unit i_alu_flags_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_a_i(a), .op_b_i(b), .op_i(op), .byte_i(byt),
    .carry_i(cin), .upd_i(upd), .ctl_set_i(cset), .ctl_clr_i(cclr),
    .result_o(result), .result_we_o(we), .flags_o(flags)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // returns {ovf, sgn, zro, aux, par, cry, result[15:0]}
  function automatic logic [21:0] ref_op(input logic [2:0] o, input logic [15:0] x,
                                         input logic [15:0] y, input logic bm, input logic c);
    int w = bm ? 8 : 16;
    int m = (1 << w) - 1;
    int ux = int'(x) & m;
    int uy = int'(y) & m;
    int cc = (o == 3'd1 || o == 3'd3) ? int'(c) : 0;
    int sx = (ux >= (1 << (w-1))) ? ux - (1 << w) : ux;
    int sy = (uy >= (1 << (w-1))) ? uy - (1 << w) : uy;
    int full, sfull, r;
    logic cy = 0, ax = 0, ov = 0;
    logic [15:0] rr;
    if (o <= 3'd1) begin
      full = ux + uy + cc; sfull = sx + sy + cc;
      cy = (full > m); ax = ((ux & 15) + (uy & 15) + cc) > 15;
      ov = (sfull >= (1 << (w-1))) || (sfull < -(1 << (w-1)));
      r = full & m;
    end else if (o <= 3'd4) begin
      full = ux - uy - cc; sfull = sx - sy - cc;
      cy = (full < 0); ax = (ux & 15) < ((uy & 15) + cc);
      ov = (sfull >= (1 << (w-1))) || (sfull < -(1 << (w-1)));
      r = full & m;
    end else if (o == 3'd5) r = ux & uy;
    else if (o == 3'd6) r = ux | uy;
    else r = ux ^ uy;
    rr = r[15:0];
    return {ov, (bm ? rr[7] : rr[15]), (rr == 16'h0), ax, ~^rr[7:0], cy, rr};
  endfunction

  task automatic run(input logic [2:0] o, input logic [15:0] x, input logic [15:0] y,
                     input logic bm, input logic c, input logic u,
                     input logic [2:0] s, input logic [2:0] k);
    logic [21:0] rf;
    string t;
    @(negedge clk);
    op = o; a = x; b = y; byt = bm; cin = c; upd = u; cset = s; cclr = k;
    rf = ref_op(o, x, y, bm, c);
    t = (o <= 3'd1) ? "R1" : (o <= 3'd4) ? "R2" : "R7";
    #2;
    chk({t, " result"}, result, rf[15:0]);
    if (bm) chk("R8 upper byte", {8'h00, result[15:8]}, 16'h0000);
    chk("R9 write-enable", {15'h0, we}, {15'h0, (o != 3'd4)});
    if (u) exp_st = rf[21:16];
    for (int i = 0; i < 3; i++)
      if (k[i]) exp_ctl[i] = 1'b0; else if (s[i]) exp_ctl[i] = 1'b1;
    @(posedge clk); #2;
    if (u) begin
      chk({t, " carry"}, {15'h0, flags[0]}, {15'h0, exp_st[0]});
      chk("R5 parity", {15'h0, flags[1]}, {15'h0, exp_st[1]});
      chk((o >= 3'd5) ? "R7 aux" : "R6 aux", {15'h0, flags[2]}, {15'h0, exp_st[2]});
      chk("R4 zero/sign", {14'h0, flags[4:3]}, {14'h0, exp_st[4:3]});
      chk((o >= 3'd5) ? "R7 overflow" : "R3 overflow", {15'h0, flags[5]}, {15'h0, exp_st[5]});
    end else begin
      chk("R10 status hold", {10'h0, flags[5:0]}, {10'h0, exp_st});
    end
    chk("R11 control bits", {13'h0, flags[8:6]}, {13'h0, exp_ctl});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R12 reset flags", {7'h0, flags}, 16'h0000);
    rst_n = 1'b1;
    // directed corners
    run(3'd0, 16'h7FFF, 16'h0001, 0, 0, 1, 3'b000, 3'b000); // R3 signed overflow
    run(3'd0, 16'hFFFF, 16'h0001, 0, 0, 1, 3'b000, 3'b000); // R1 carry + R4 zero
    run(3'd1, 16'hFFFE, 16'h0000, 0, 1, 1, 3'b000, 3'b000); // R1 ADC to FFFF
    run(3'd0, 16'h120F, 16'h0001, 0, 0, 1, 3'b000, 3'b000); // R6 nibble carry
    run(3'd0, 16'hAB7F, 16'h3401, 1, 0, 1, 3'b000, 3'b000); // R8 byte overflow
    run(3'd2, 16'h0000, 16'h0001, 0, 0, 1, 3'b000, 3'b000); // R2 borrow
    run(3'd3, 16'h0010, 16'h0000, 1, 1, 1, 3'b000, 3'b000); // R2/R6 borrow from nibble
    run(3'd4, 16'h5A5A, 16'h5A5A, 0, 0, 1, 3'b000, 3'b000); // R9 compare equal
    run(3'd4, 16'h8000, 16'h0001, 0, 0, 1, 3'b000, 3'b000); // R9/R3 compare overflow
    run(3'd5, 16'hF0F0, 16'h0FF0, 0, 0, 1, 3'b111, 3'b000); // R7 + R11 set all
    run(3'd7, 16'hFFFF, 16'hFFFF, 0, 0, 1, 3'b010, 3'b111); // R11 clear wins
    run(3'd0, 16'hFFFF, 16'hFFFF, 0, 1, 0, 3'b101, 3'b000); // R10 no update
    run(3'd6, 16'h0000, 16'h0003, 1, 0, 1, 3'b000, 3'b001); // R5 even parity
    // random
    for (int n = 0; n < 3000; n++) begin
      run(3'($urandom % 8), 16'($urandom), 16'($urandom), 1'($urandom % 3 == 0),
          1'($urandom), 1'($urandom % 4 != 0),
          ($urandom % 5 == 0) ? 3'($urandom) : 3'b000,
          ($urandom % 5 == 0) ? 3'($urandom) : 3'b000);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule